// File: doc/BRIEF.md
# SCSI Synchronous Transfer Gross Error Checker

This block watches one synchronous SCSI transfer from the controller's side. It flags protocol gross errors as they happen. It keeps a signed count of outstanding offset: each REQ pulse adds one and each ACK pulse takes one away. It also watches the read and write strobes of the data FIFO against that FIFO's full and empty flags, the phase-change strobe and the transfer-start strobe. Whether a given offset event is an error depends on whether the controller acts as initiator or as target.

When one or more error conditions are detected in a clock cycle, the block raises a single-cycle error pulse on the next cycle. It presents a 3-bit cause code with that pulse. An interrupt or status stage upstream can latch the code. The data path, bus synchronisation and the interrupt register belong to neighbouring blocks.

Top module: `scsi_gross_err_chk`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `gross_err` is 0, `err_cause` is 0 and the offset count is 0. A following initiator phase change therefore raises no error.
- R2: A cycle with `fifo_rd` high while `fifo_empty` is high is a data underflow, cause code 1. A read with `fifo_empty` low is not an error.
- R3: A cycle with `fifo_wr` high while `fifo_full` is high is a data overflow, cause code 2. A write with `fifo_full` low is not an error.
- R4: In target mode (`tgt_mode`=1), an ACK that would take the offset count below zero is an offset underflow, cause code 3. The count then keeps its previous value. In initiator mode such an ACK is not flagged.
- R5: In initiator mode (`tgt_mode`=0), a REQ that would take the offset count above `max_ofs` is an offset overflow, cause code 4. Reaching exactly `max_ofs` is legal, and the count keeps its previous value on the error. In target mode, REQs beyond `max_ofs` are not flagged.
- R6: In initiator mode, `phase_chg` while the offset count is nonzero (positive or negative) is cause code 5. In target mode a phase change is never flagged. In both modes a phase change clears the count to 0, and the clear takes effect over any REQ or ACK in the same cycle.
- R7: `xfer_start` with `xfer_sync_rx`=0 while `fifo_empty`=0 is a residual-data error, cause code 6. A start with `xfer_sync_rx`=1, or with an empty FIFO, is not an error.
- R8: When several conditions are detected in one cycle, the lowest cause code among them is reported.
- R9: The error is reported on the clock edge that follows the detecting cycle, as a `gross_err` pulse lasting one cycle. `err_cause` is 0 whenever `gross_err` is 0.
- R10: The offset count adds one per REQ and subtracts one per ACK. A REQ and an ACK in the same cycle leave it unchanged. At the limits of its signed range the count saturates rather than wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tgt_mode | input | 1 | 1 = target role, 0 = initiator role |
| max_ofs | input | OFS_W (4) | Programmed maximum synchronous offset |
| req_pulse | input | 1 | One-cycle strobe per REQ seen or sent |
| ack_pulse | input | 1 | One-cycle strobe per ACK seen or sent |
| fifo_rd | input | 1 | Data FIFO read strobe |
| fifo_wr | input | 1 | Data FIFO write strobe |
| fifo_full | input | 1 | Data FIFO full flag |
| fifo_empty | input | 1 | Data FIFO empty flag |
| phase_chg | input | 1 | Bus phase-change strobe |
| xfer_start | input | 1 | Transfer-start strobe |
| xfer_sync_rx | input | 1 | With `xfer_start`: 1 = synchronous data receive |
| gross_err | output | 1 | One-cycle gross error pulse |
| err_cause | output | 3 | Cause code of the reported error, 0 when idle |

## Verification
The offset counter is driven with four kinds of pattern:
- lone REQ runs up to and past a small maximum and a zero maximum, which separates a correct threshold from an off-by-one;
- lone ACKs from zero in each mode, which separates the mode-dependent rules;
- REQ and ACK together at the limit, which shows that simultaneous pulses cancel;
- an error followed by draining ACKs and a phase change, which shows that the count held rather than stepped past the limit.

The FIFO and transfer-start checks are each run with the flag set and with it clear. Combined-condition cycles confirm that the lowest code wins. A cycle after each error confirms that the pulse drops.

// File: rtl/gec_pkg.sv
package gec_pkg;
   localparam int CAUSE_W   = 3;
   localparam int NUM_CAUSE = 6;

   typedef enum logic [CAUSE_W-1:0] {
      GEC_NONE       = 3'd0,
      GEC_DATA_UNDER = 3'd1,
      GEC_DATA_OVER  = 3'd2,
      GEC_OFS_UNDER  = 3'd3,
      GEC_OFS_OVER   = 3'd4,
      GEC_PHASE_OFS  = 3'd5,
      GEC_RESIDUAL   = 3'd6
   } gec_cause_e;
endpackage

// File: rtl/gec_offset_track.sv
module gec_offset_track #(
   parameter int OFS_W = 4,
   parameter int CNT_W = OFS_W + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tgt_mode,
   input  logic [OFS_W-1:0]        max_ofs,
   input  logic                    req_pulse,
   input  logic                    ack_pulse,
   input  logic                    phase_chg,
   output logic                    ofs_under,
   output logic                    ofs_over,
   output logic                    phase_busy,
   output logic signed [CNT_W-1:0] ofs_cnt
);
   localparam int SUM_W = CNT_W + 1;

   logic signed [CNT_W-1:0] cnt_q, cnt_d;
   logic [SUM_W-1:0]        sum_w;
   logic [SUM_W-1:0]        max_ext;
   logic                    sum_neg, sat_hi, sat_lo;

   always_comb begin
      sum_w   = {cnt_q[CNT_W-1], cnt_q}
              + {{CNT_W{1'b0}}, req_pulse}
              - {{CNT_W{1'b0}}, ack_pulse};
      max_ext = {{(SUM_W-OFS_W){1'b0}}, max_ofs};
      sum_neg = sum_w[SUM_W-1];
      sat_hi  = !sum_neg && sum_w[CNT_W-1];
      sat_lo  = sum_neg && !sum_w[CNT_W-1];
   end

   // R4 / R5 / R6: mode-dependent offset rules
   assign ofs_under  = tgt_mode && ack_pulse && sum_neg;
   assign ofs_over   = !tgt_mode && req_pulse && !sum_neg && (sum_w > max_ext);
   assign phase_busy = !tgt_mode && phase_chg && (cnt_q != '0);

   // R10: count with saturation, R6: phase change clears
   always_comb begin
      if (phase_chg)                 cnt_d = '0;
      else if (ofs_under || ofs_over) cnt_d = cnt_q;
      else if (sat_hi)                cnt_d = {1'b0, {(CNT_W-1){1'b1}}};
      else if (sat_lo)                cnt_d = {1'b1, {(CNT_W-1){1'b0}}};
      else                            cnt_d = sum_w[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign ofs_cnt = cnt_q;
endmodule

// File: rtl/gec_fifo_watch.sv
module gec_fifo_watch (
   input  logic fifo_rd,
   input  logic fifo_wr,
   input  logic fifo_full,
   input  logic fifo_empty,
   input  logic xfer_start,
   input  logic xfer_sync_rx,
   output logic data_under,
   output logic data_over,
   output logic residual
);
   assign data_under = fifo_rd && fifo_empty;
   assign data_over  = fifo_wr && fifo_full;
   assign residual   = xfer_start && !xfer_sync_rx && !fifo_empty;
endmodule

// File: rtl/gec_cause_pick.sv
module gec_cause_pick
   import gec_pkg::*;
#(
   parameter int N = NUM_CAUSE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N-1:0]       hit,      // bit i stands for code i+1
   output logic               err_q,
   output logic [CAUSE_W-1:0] cause_q
);
   logic [N:0]         none_below;
   logic [N-1:0]       sel;
   logic [CAUSE_W-1:0] code_d;

   assign none_below[0] = 1'b1;
   for (genvar i = 0; i < N; i++) begin : g_prio
      assign sel[i]          = hit[i] && none_below[i];
      assign none_below[i+1] = none_below[i] && !hit[i];
   end

   always_comb begin
      code_d = '0;
      for (int i = 0; i < N; i++)
         if (sel[i]) code_d = code_d | CAUSE_W'(i + 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q   <= 1'b0;
         cause_q <= '0;
      end else begin
         err_q   <= |hit;
         cause_q <= code_d;
      end
   end
endmodule

// File: rtl/scsi_gross_err_chk.sv
module scsi_gross_err_chk
   import gec_pkg::*;
#(
   parameter int OFS_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tgt_mode,
   input  logic [OFS_W-1:0]   max_ofs,
   input  logic               req_pulse,
   input  logic               ack_pulse,
   input  logic               fifo_rd,
   input  logic               fifo_wr,
   input  logic               fifo_full,
   input  logic               fifo_empty,
   input  logic               phase_chg,
   input  logic               xfer_start,
   input  logic               xfer_sync_rx,
   output logic               gross_err,
   output logic [CAUSE_W-1:0] err_cause
);
   localparam int CNT_W = OFS_W + 2;

   if (OFS_W < 1 || OFS_W > 8) begin : g_bad_ofs_w
      $error("OFS_W must lie in 1..8");
   end
   if ((1 << CAUSE_W) <= NUM_CAUSE) begin : g_bad_cause_w
      $error("cause code too narrow");
   end

   logic                    d_under, d_over, resid;
   logic                    o_under, o_over, ph_busy;
   logic signed [CNT_W-1:0] ofs_cnt;
   logic [NUM_CAUSE-1:0]    hit;

   gec_offset_track #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_ofs (
      .clk(clk), .rst_n(rst_n), .tgt_mode(tgt_mode), .max_ofs(max_ofs),
      .req_pulse(req_pulse), .ack_pulse(ack_pulse), .phase_chg(phase_chg),
      .ofs_under(o_under), .ofs_over(o_over), .phase_busy(ph_busy),
      .ofs_cnt(ofs_cnt)
   );

   gec_fifo_watch u_fifo (
      .fifo_rd(fifo_rd), .fifo_wr(fifo_wr), .fifo_full(fifo_full),
      .fifo_empty(fifo_empty), .xfer_start(xfer_start),
      .xfer_sync_rx(xfer_sync_rx), .data_under(d_under),
      .data_over(d_over), .residual(resid)
   );

   // R8: bit order is the priority order, code 1 first
   assign hit = {resid, ph_busy, o_over, o_under, d_over, d_under};

   gec_cause_pick #(.N(NUM_CAUSE)) u_pick (
      .clk(clk), .rst_n(rst_n), .hit(hit),
      .err_q(gross_err), .cause_q(err_cause)
   );
endmodule

// File: rtl/gec_checker.sv
module gec_checker #(
   parameter int OFS_W = 4,
   parameter int CNT_W = OFS_W + 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tgt_mode,
   input logic [OFS_W-1:0]        max_ofs,
   input logic                    req_pulse,
   input logic                    ack_pulse,
   input logic                    fifo_rd,
   input logic                    fifo_wr,
   input logic                    fifo_full,
   input logic                    fifo_empty,
   input logic                    phase_chg,
   input logic                    gross_err,
   input logic [2:0]              err_cause,
   input logic signed [CNT_W-1:0] ofs_cnt
);
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!gross_err && err_cause == 3'd0 && ofs_cnt == '0));

   a_r9_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      !gross_err |-> err_cause == 3'd0);

   a_r9_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      gross_err |-> (err_cause >= 3'd1 && err_cause <= 3'd6));

   a_r2_rd_empty: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fifo_rd && fifo_empty)) |-> (gross_err && err_cause == 3'd1));

   a_r3_wr_full: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fifo_wr && fifo_full)) |-> (gross_err && err_cause <= 3'd2));

   a_r6_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(phase_chg)) |-> ofs_cnt == '0);

   a_r5_over_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!tgt_mode && req_pulse && !ack_pulse && !phase_chg
                             && !ofs_cnt[CNT_W-1]
                             && ofs_cnt >= $signed({2'b00, max_ofs})))
      |-> (gross_err && $stable(ofs_cnt)));

   a_r4_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(tgt_mode && ack_pulse && !req_pulse && !phase_chg
                             && ofs_cnt == '0))
      |-> (gross_err && ofs_cnt == '0));
endmodule

bind scsi_gross_err_chk gec_checker #(.OFS_W(OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tgt_mode(tgt_mode), .max_ofs(max_ofs),
   .req_pulse(req_pulse), .ack_pulse(ack_pulse), .fifo_rd(fifo_rd),
   .fifo_wr(fifo_wr), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
   .phase_chg(phase_chg), .gross_err(gross_err), .err_cause(err_cause),
   .ofs_cnt(ofs_cnt)
);

// File: tb/scsi_gross_err_chk_bench.sv
module scsi_gross_err_chk_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tgt_mode = 1'b0;
   logic [3:0] max_ofs = 4'd3;
   logic       req_pulse = 0, ack_pulse = 0, fifo_rd = 0, fifo_wr = 0;
   logic       fifo_full = 0, fifo_empty = 1, phase_chg = 0;
   logic       xfer_start = 0, xfer_sync_rx = 0;
   logic       gross_err;
   logic [2:0] err_cause;
   int         n_run = 0, n_fail = 0;
   bit         done = 0;

   always #4 clk = ~clk;   // 125 MHz

   scsi_gross_err_chk u_scsi_gross_err_chk (
      .clk(clk), .rst_n(rst_n), .tgt_mode(tgt_mode), .max_ofs(max_ofs),
      .req_pulse(req_pulse), .ack_pulse(ack_pulse), .fifo_rd(fifo_rd),
      .fifo_wr(fifo_wr), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
      .phase_chg(phase_chg), .xfer_start(xfer_start),
      .xfer_sync_rx(xfer_sync_rx), .gross_err(gross_err), .err_cause(err_cause)
   );

   // one clock with the strobes as set, then strobes dropped at negedge
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      req_pulse = 0; ack_pulse = 0; fifo_rd = 0; fifo_wr = 0;
      phase_chg = 0; xfer_start = 0;
   endtask

   task automatic expect_out(string tag, logic e, logic [2:0] c);
      n_run++;
      if (gross_err !== e || err_cause !== c) begin
         n_fail++;
         $display("FAIL %s: got err=%b cause=%0d, expected err=%b cause=%0d",
                  tag, gross_err, err_cause, e, c);
      end
   endtask

   task automatic t_reset();
      fifo_rd = 1; phase_chg = 1; cyc();   // reset-cycle activity is discarded
      rst_n = 1;
      expect_out("R1 reset state", 0, 0);
      tgt_mode = 0; phase_chg = 1; cyc();
      expect_out("R1 count zero after reset", 0, 0);
   endtask

   task automatic t_fifo();
      fifo_empty = 1; fifo_rd = 1; cyc();
      expect_out("R2 read while empty", 1, 1);
      cyc();
      expect_out("R9 pulse drops", 0, 0);
      fifo_empty = 0; fifo_rd = 1; cyc();
      expect_out("R2 read with data", 0, 0);
      fifo_full = 1; fifo_wr = 1; cyc();
      expect_out("R3 write while full", 1, 2);
      fifo_full = 0; fifo_wr = 1; cyc();
      expect_out("R3 write with room", 0, 0);
      fifo_empty = 1;
   endtask

   task automatic t_target();
      tgt_mode = 1; phase_chg = 1; cyc();
      ack_pulse = 1; cyc();
      expect_out("R4 ack before req", 1, 3);
      req_pulse = 1; cyc();
      expect_out("R4 req in target", 0, 0);
      ack_pulse = 1; cyc();
      expect_out("R10 matching ack", 0, 0);
      ack_pulse = 1; cyc();
      expect_out("R4 count held at zero", 1, 3);
      max_ofs = 4'd1;
      for (int i = 0; i < 3; i++) begin req_pulse = 1; cyc(); end
      expect_out("R5 no overflow in target", 0, 0);
      phase_chg = 1; cyc();
      expect_out("R6 target phase ignored", 0, 0);
      ack_pulse = 1; cyc();
      expect_out("R6 target phase cleared count", 1, 3);
   endtask

   task automatic t_initiator();
      tgt_mode = 0; max_ofs = 4'd3; phase_chg = 1; cyc();
      for (int i = 0; i < 3; i++) begin req_pulse = 1; cyc(); end
      expect_out("R5 exactly at max", 0, 0);
      req_pulse = 1; ack_pulse = 1; cyc();
      expect_out("R10 req+ack cancel at max", 0, 0);
      req_pulse = 1; cyc();
      expect_out("R5 above max", 1, 4);
      for (int i = 0; i < 3; i++) begin ack_pulse = 1; cyc(); end
      phase_chg = 1; cyc();
      expect_out("R10 count held at max", 0, 0);
      max_ofs = 4'd0; req_pulse = 1; cyc();
      expect_out("R5 zero max", 1, 4);
      max_ofs = 4'd3; req_pulse = 1; cyc();
      phase_chg = 1; cyc();
      expect_out("R6 phase with offset", 1, 5);
      phase_chg = 1; cyc();
      expect_out("R6 count cleared", 0, 0);
      ack_pulse = 1; cyc();
      expect_out("R4 no underflow in initiator", 0, 0);
      phase_chg = 1; cyc();
      expect_out("R6 negative offset", 1, 5);
   endtask

   task automatic t_residual();
      fifo_empty = 0; xfer_start = 1; xfer_sync_rx = 0; cyc();
      expect_out("R7 residual data", 1, 6);
      xfer_start = 1; xfer_sync_rx = 1; cyc();
      expect_out("R7 sync receive allowed", 0, 0);
      fifo_empty = 1; xfer_start = 1; xfer_sync_rx = 0; cyc();
      expect_out("R7 empty fifo", 0, 0);
   endtask

   task automatic t_priority();
      fifo_empty = 1; fifo_full = 1; fifo_rd = 1; fifo_wr = 1; cyc();
      expect_out("R8 under beats over", 1, 1);
      tgt_mode = 1; phase_chg = 1; cyc();
      fifo_wr = 1; ack_pulse = 1; cyc();
      expect_out("R8 over beats offset under", 1, 2);
      fifo_full = 0; tgt_mode = 0; max_ofs = 4'd0;
      req_pulse = 1; fifo_empty = 0; xfer_start = 1; cyc();
      expect_out("R8 offset over beats residual", 1, 4);
      fifo_empty = 1; cyc();
      expect_out("R9 idle after error", 0, 0);
   endtask

   initial begin
      #200000000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got no finish, expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_fifo();
      t_target();
      t_initiator();
      t_residual();
      t_priority();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule